// File: doc/BRIEF.md
# Li-ion Charge Phase Controller

This block sequences one charge cycle for a single lithium-ion cell. It works only on digitized comparator flags: whether the supply is qualified, where the battery voltage sits against the low and recharge thresholds, whether the battery has reached the regulation voltage, whether the charge current has fallen below the termination level, and whether the pack is hot or cold. A slow timer tick drives three counted windows: a precharge limit, a fast-charge safety limit and a detection probe interval.

From these flags the controller selects the charge phase. It drives a code for the current level the analog charger should regulate, and an enable for the probe current source used to check whether a battery is present. It also drives a charge-active status bit and a one-cycle event pulse for each phase entry, which a separate interrupt block can latch. Analog regulation, thermal current foldback and register access are outside this block. The enables and the suspend-mode bits arrive as plain inputs.

Top module: `chg_phase_ctrl`

## Requirements
- R1: The phase is RESET (code 0) while the supply is not qualified. The supply is qualified only when vin_uvlo_ok, vin_headroom_ok and vin_ovp_ok are all 1 and susp_mode is not 2'b00. Loss of qualification moves any phase to RESET on the next clock, and a qualified supply moves RESET to IDLE (code 1).
- R2: In IDLE with chg_en=1, the controller enters PRECH (code 2) on the next clock. PRECH drives cur_sel=1 (precharge level) and chg_active=1.
- R3: In PRECH, bat_low_ok=1 moves the phase to CC (code 3), which drives cur_sel=2 (fast-charge level).
- R4: If PRE_TICKS ticks are counted in PRECH before bat_low_ok rises, the phase becomes FAULT (code 7) on the clock after the last tick. FAULT drives cur_sel=0 and chg_active=0.
- R5: In CC, bat_at_reg=1 moves the phase to CV (code 4). In CV, the phase moves to DONE (code 5, cur_sel=0, chg_active=0) only when term_en=1 and ichg_below_term=1. With term_en=0, the phase stays in CV.
- R6: A safety count of ticks spent in CC and CV starts at zero at each cycle start. When it reaches SAFE_TICKS, the phase becomes FAULT on the next clock.
- R7: FAULT is held until chg_en=0, which gives IDLE, or until the supply qualification is lost, which gives RESET.
- R8: With term_en=1 and pack_hot or pack_cold set in PRECH, CC or CV, the phase becomes SUSP (code 6): cur_sel=0 and chg_active stays 1. Neither timer counts in SUSP. When both flags clear, the phase returns to the phase it was suspended from and the counts continue from where they stopped.
- R9: With term_en=0, pack_hot and pack_cold have no effect on the phase.
- R10: In DONE, bat_low_ok=0 starts a probe: det_src_en=1 and cur_sel=1 for DET_TICKS ticks. On the clock after the last tick, bat_rch_ok=0 starts a new cycle in PRECH. Otherwise the probe ends with det_src_en=0 and the phase stays in DONE.
- R11: In DONE with no probe running, bat_low_ok=1 together with bat_rch_ok=0 starts a new cycle in PRECH.
- R12: On the clock edge where the phase changes, evt bit [new phase code] is 1 for exactly one cycle. In every other cycle evt is all zero.
- R13: chg_en=0 in PRECH, CC, CV, DONE or SUSP gives IDLE on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vin_uvlo_ok | input | 1 | Supply above undervoltage lockout |
| vin_headroom_ok | input | 1 | Supply above battery plus headroom margin |
| vin_ovp_ok | input | 1 | Supply below overvoltage limit |
| susp_mode | input | 2 | Suspend-mode bits; 2'b00 holds the charger in reset |
| chg_en | input | 1 | Charge enable |
| term_en | input | 1 | Termination enable (also gates pack temperature checks) |
| bat_low_ok | input | 1 | Battery above low-voltage threshold |
| bat_rch_ok | input | 1 | Battery above recharge threshold |
| bat_at_reg | input | 1 | Battery has reached regulation voltage |
| ichg_below_term | input | 1 | Charge current below termination level |
| pack_hot | input | 1 | Pack above high temperature limit |
| pack_cold | input | 1 | Pack below low temperature limit |
| tick | input | 1 | Timer tick, one cycle wide |
| phase_o | output | 3 | Current phase code |
| cur_sel_o | output | 2 | 0 off, 1 precharge level, 2 fast-charge level |
| det_src_en_o | output | 1 | Detection probe current source enable |
| chg_active_o | output | 1 | Charging active status |
| evt_o | output | 8 | One-cycle phase entry pulses, bit index = phase code |

## Verification
The bench places the precharge and safety timeouts exactly on their tick counts, one clock before and at the expiry. A timer that is off by one would fault a cycle early or late. It suspends fast charge partway through the safety window and ticks for a long time while suspended. A design that kept counting, or cleared the count on resume, would fault too early or too late. The bench runs the detection probe with and without a battery present. A broken probe would either restart charging into an empty socket or miss an inserted cell. It also checks that temperature flags do nothing with termination disabled, that FAULT survives until the enable drops, and that each entry pulse names the right phase for one cycle only.

// File: rtl/chg_pkg.sv
package chg_pkg;
    localparam int NUM_PHASES = 8;

    typedef enum logic [2:0] {
        PH_RESET = 3'd0,
        PH_IDLE  = 3'd1,
        PH_PRE   = 3'd2,
        PH_CC    = 3'd3,
        PH_CV    = 3'd4,
        PH_DONE  = 3'd5,
        PH_SUSP  = 3'd6,
        PH_FAULT = 3'd7
    } phase_e;

    typedef enum logic [1:0] {
        CUR_OFF  = 2'd0,
        CUR_PRE  = 2'd1,
        CUR_FAST = 2'd2
    } cur_e;
endpackage

// File: rtl/chg_qualify.sv
module chg_qualify (
    input  logic       vin_uvlo_ok,
    input  logic       vin_headroom_ok,
    input  logic       vin_ovp_ok,
    input  logic [1:0] susp_mode,
    input  logic       term_en,
    input  logic       pack_hot,
    input  logic       pack_cold,
    output logic       supply_ok,
    output logic       temp_bad
);
    always_comb begin
        supply_ok = vin_uvlo_ok && vin_headroom_ok && vin_ovp_ok && (susp_mode != 2'b00);
        temp_bad  = term_en && (pack_hot || pack_cold);
    end
endmodule

// File: rtl/chg_tick_timer.sv
module chg_tick_timer #(
    parameter int LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_s;

    tmr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.cnt = '0;
        end else if (run && tick && (st_q.cnt != LIM)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        expired = (st_q.cnt == LIM);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a paused timer holds its count
    a_r8_paused_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear) |=> $stable(st_q.cnt));

    // R4 / R6: expiry stays until the next cycle start clears it
    a_r4_expiry_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clear) |=> expired);
endmodule

// File: rtl/chg_probe.sv
module chg_probe #(
    parameter int DET_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic start,
    input  logic tick,
    output logic active,
    output logic finished
);
    localparam int CW = $clog2(DET_TICKS + 1);
    localparam logic [CW-1:0] LIM = CW'(DET_TICKS);

    typedef struct packed {
        logic          act;
        logic [CW-1:0] cnt;
    } prb_s;

    prb_s st_d, st_q;

    always_comb begin
        st_d     = st_q;
        finished = st_q.act && (st_q.cnt == LIM);
        active   = st_q.act;
        if (clear || finished) begin
            st_d.act = 1'b0;
            st_d.cnt = '0;
        end else if (start && !st_q.act) begin
            st_d.act = 1'b1;
            st_d.cnt = '0;
        end else if (st_q.act && tick) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10: a running probe is not dropped before its interval ends
    a_r10_probe_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clear && !finished) |=> active);
endmodule

// File: rtl/chg_phase_ctrl.sv
module chg_phase_ctrl
    import chg_pkg::*;
#(
    parameter int PRE_TICKS  = 8,
    parameter int SAFE_TICKS = 20,
    parameter int DET_TICKS  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  vin_uvlo_ok,
    input  logic                  vin_headroom_ok,
    input  logic                  vin_ovp_ok,
    input  logic [1:0]            susp_mode,
    input  logic                  chg_en,
    input  logic                  term_en,
    input  logic                  bat_low_ok,
    input  logic                  bat_rch_ok,
    input  logic                  bat_at_reg,
    input  logic                  ichg_below_term,
    input  logic                  pack_hot,
    input  logic                  pack_cold,
    input  logic                  tick,
    output logic [2:0]            phase_o,
    output logic [1:0]            cur_sel_o,
    output logic                  det_src_en_o,
    output logic                  chg_active_o,
    output logic [NUM_PHASES-1:0] evt_o
);
    typedef struct packed {
        phase_e                phase;
        phase_e                ret;
        logic [NUM_PHASES-1:0] evt;
    } ctl_s;

    ctl_s st_d, st_q;

    logic supply_ok, temp_bad;
    logic pre_exp, safe_exp;
    logic cycle_start;
    logic probe_active, probe_done, probe_start, probe_clear;
    logic pre_run, safe_run;

    chg_qualify u_qual (
        .vin_uvlo_ok     (vin_uvlo_ok),
        .vin_headroom_ok (vin_headroom_ok),
        .vin_ovp_ok      (vin_ovp_ok),
        .susp_mode       (susp_mode),
        .term_en         (term_en),
        .pack_hot        (pack_hot),
        .pack_cold       (pack_cold),
        .supply_ok       (supply_ok),
        .temp_bad        (temp_bad)
    );

    always_comb begin
        pre_run     = (st_q.phase == PH_PRE);
        safe_run    = (st_q.phase == PH_CC) || (st_q.phase == PH_CV);
        probe_start = (st_q.phase == PH_DONE) && !bat_low_ok && !probe_active;
    end

    chg_tick_timer #(.LIMIT(PRE_TICKS)) u_pre_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cycle_start),
        .run     (pre_run),
        .tick    (tick),
        .expired (pre_exp)
    );

    chg_tick_timer #(.LIMIT(SAFE_TICKS)) u_safe_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cycle_start),
        .run     (safe_run),
        .tick    (tick),
        .expired (safe_exp)
    );

    chg_probe #(.DET_TICKS(DET_TICKS)) u_probe (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (probe_clear),
        .start    (probe_start),
        .tick     (tick),
        .active   (probe_active),
        .finished (probe_done)
    );

    always_comb begin
        st_d     = st_q;
        st_d.evt = '0;
        if (!supply_ok) begin
            st_d.phase = PH_RESET;
        end else begin
            case (st_q.phase)
                PH_RESET: st_d.phase = PH_IDLE;
                PH_IDLE:  if (chg_en) st_d.phase = PH_PRE;
                PH_PRE: begin
                    if (!chg_en)         st_d.phase = PH_IDLE;
                    else if (temp_bad)   begin st_d.phase = PH_SUSP; st_d.ret = PH_PRE; end
                    else if (pre_exp)    st_d.phase = PH_FAULT;
                    else if (bat_low_ok) st_d.phase = PH_CC;
                end
                PH_CC: begin
                    if (!chg_en)         st_d.phase = PH_IDLE;
                    else if (temp_bad)   begin st_d.phase = PH_SUSP; st_d.ret = PH_CC; end
                    else if (safe_exp)   st_d.phase = PH_FAULT;
                    else if (bat_at_reg) st_d.phase = PH_CV;
                end
                PH_CV: begin
                    if (!chg_en)       st_d.phase = PH_IDLE;
                    else if (temp_bad) begin st_d.phase = PH_SUSP; st_d.ret = PH_CV; end
                    else if (safe_exp) st_d.phase = PH_FAULT;
                    else if (term_en && ichg_below_term) st_d.phase = PH_DONE;
                end
                PH_DONE: begin
                    if (!chg_en) begin
                        st_d.phase = PH_IDLE;
                    end else if (probe_done) begin
                        if (!bat_rch_ok) st_d.phase = PH_PRE;
                    end else if (!probe_active && bat_low_ok && !bat_rch_ok) begin
                        st_d.phase = PH_PRE;
                    end
                end
                PH_SUSP: begin
                    if (!chg_en)        st_d.phase = PH_IDLE;
                    else if (!temp_bad) st_d.phase = st_q.ret;
                end
                PH_FAULT: if (!chg_en) st_d.phase = PH_IDLE;
                default:  st_d.phase = PH_RESET;
            endcase
        end
        if (st_d.phase != st_q.phase) st_d.evt[st_d.phase] = 1'b1;
        cycle_start = (st_d.phase == PH_PRE) &&
                      ((st_q.phase == PH_IDLE) || (st_q.phase == PH_DONE));
        probe_clear = (st_d.phase != PH_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_RESET;
            st_q.ret   <= PH_PRE;
            st_q.evt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        phase_o      = st_q.phase;
        evt_o        = st_q.evt;
        det_src_en_o = probe_active;
        chg_active_o = (st_q.phase == PH_PRE) || (st_q.phase == PH_CC) ||
                       (st_q.phase == PH_CV)  || (st_q.phase == PH_SUSP);
        if ((st_q.phase == PH_CC) || (st_q.phase == PH_CV)) cur_sel_o = CUR_FAST;
        else if ((st_q.phase == PH_PRE) || probe_active)     cur_sel_o = CUR_PRE;
        else                                                 cur_sel_o = CUR_OFF;
    end

    // R1: losing the supply always lands in reset
    a_r1_drop_to_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (phase_o == PH_RESET));

    // R4: precharge timeout faults
    a_r4_pre_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_PRE) && pre_exp && chg_en && supply_ok && !temp_bad)
        |=> (phase_o == PH_FAULT));

    // R7: fault is latched while enabled and powered
    a_r7_fault_latch: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase_o == PH_FAULT) && chg_en && supply_ok) |=> (phase_o == PH_FAULT));

    // R8: resume returns to the suspended phase
    a_r8_resume_same: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_SUSP) && chg_en && supply_ok && !temp_bad)
        |=> (phase_o == $past(st_q.ret)));

    // R9: with termination off the fast phase ignores temperature
    a_r9_temp_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!term_en && (st_q.phase == PH_CC) && chg_en && supply_ok && !safe_exp && !bat_at_reg)
        |=> (phase_o == PH_CC));

    // R10: the probe source only runs in done
    a_r10_probe_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        det_src_en_o |-> (phase_o == PH_DONE));

    // R12: event pulses are one-hot and mark every phase change
    a_r12_evt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(evt_o));
    a_r12_evt_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != $past(phase_o)) |-> $onehot(evt_o));
endmodule

// File: tb/tb_chg_phase_ctrl.sv
module tb_chg_phase_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vin_uvlo_ok = 0, vin_headroom_ok = 0, vin_ovp_ok = 0;
    logic [1:0] susp_mode = 2'b00;
    logic chg_en = 0, term_en = 0, bat_low_ok = 0, bat_rch_ok = 1;
    logic bat_at_reg = 0, ichg_below_term = 0, pack_hot = 0, pack_cold = 0, tick = 0;
    logic [2:0] phase_o;
    logic [1:0] cur_sel_o;
    logic det_src_en_o, chg_active_o;
    logic [7:0] evt_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    chg_phase_ctrl #(.PRE_TICKS(8), .SAFE_TICKS(20), .DET_TICKS(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .vin_uvlo_ok(vin_uvlo_ok), .vin_headroom_ok(vin_headroom_ok), .vin_ovp_ok(vin_ovp_ok),
        .susp_mode(susp_mode), .chg_en(chg_en), .term_en(term_en),
        .bat_low_ok(bat_low_ok), .bat_rch_ok(bat_rch_ok), .bat_at_reg(bat_at_reg),
        .ichg_below_term(ichg_below_term), .pack_hot(pack_hot), .pack_cold(pack_cold),
        .tick(tick), .phase_o(phase_o), .cur_sel_o(cur_sel_o),
        .det_src_en_o(det_src_en_o), .chg_active_o(chg_active_o), .evt_o(evt_o)
    );

    typedef struct {
        string      tag;
        logic [2:0] ph;
        logic [1:0] cur;
        logic       act;
        logic       det;
        logic [7:0] evt;
    } exp_t;

    exp_t sb[$];
    exp_t cur_item;

    // scoreboard monitor: compares away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            cur_item = sb.pop_front();
            n_tests++;
            if (phase_o !== cur_item.ph || cur_sel_o !== cur_item.cur ||
                chg_active_o !== cur_item.act || det_src_en_o !== cur_item.det ||
                evt_o !== cur_item.evt) begin
                n_fail++;
                $display("FAIL %s: got ph=%0d cur=%0d act=%0b det=%0b evt=%b, exp ph=%0d cur=%0d act=%0b det=%0b evt=%b",
                    cur_item.tag, phase_o, cur_sel_o, chg_active_o, det_src_en_o, evt_o,
                    cur_item.ph, cur_item.cur, cur_item.act, cur_item.det, cur_item.evt);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // driver pushes the expected item; entered = phase changed at the last edge
    task automatic chk(input string tag, input int ph, input int cur, input bit act,
                       input bit det, input bit entered);
        exp_t e;
        e.tag = tag;
        e.ph  = 3'(ph);
        e.cur = 2'(cur);
        e.act = act;
        e.det = det;
        e.evt = entered ? (8'd1 << ph) : 8'd0;
        sb.push_back(e);
    endtask

    initial begin
        #(20 * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(0);
        chk("R1 reset state", 0, 0, 0, 0, 0);
        step(2);
        chk("R1 held without supply", 0, 0, 0, 0, 0);
        vin_uvlo_ok = 1; vin_headroom_ok = 1; vin_ovp_ok = 1;
        step(2);
        chk("R1 suspend bits 00 hold reset", 0, 0, 0, 0, 0);
        susp_mode = 2'b01;
        step(1);
        chk("R1 reset to idle", 1, 0, 0, 0, 1);
        step(2);
        chk("R2 idle without enable", 1, 0, 0, 0, 0);
        chg_en = 1;
        step(1);
        chk("R2 enter precharge", 2, 1, 1, 0, 1);

        tick = 1;
        step(8);
        chk("R4 precharge at limit", 2, 1, 1, 0, 0);
        step(1);
        chk("R4 precharge timeout fault", 7, 0, 0, 0, 1);
        tick = 0;
        step(3);
        chk("R7 fault held", 7, 0, 0, 0, 0);
        chg_en = 0;
        step(1);
        chk("R7 fault cleared by enable", 1, 0, 0, 0, 1);
        chg_en = 1;
        step(1);
        chk("R2 new cycle", 2, 1, 1, 0, 1);
        bat_low_ok = 1;
        step(1);
        chk("R3 fast charge", 3, 2, 1, 0, 1);

        tick = 1;
        step(10);
        tick = 0;
        term_en = 1; pack_hot = 1;
        step(1);
        chk("R8 enter suspend", 6, 0, 1, 0, 1);
        tick = 1;
        step(30);
        tick = 0;
        chk("R8 suspend with ticks", 6, 0, 1, 0, 0);
        pack_hot = 0;
        step(1);
        chk("R8 resume to fast", 3, 2, 1, 0, 1);
        tick = 1;
        step(10);
        chk("R6 safety at limit", 3, 2, 1, 0, 0);
        tick = 0;
        step(1);
        chk("R6 safety fault", 7, 0, 0, 0, 1);

        vin_uvlo_ok = 0;
        step(1);
        chk("R1 supply loss clears fault", 0, 0, 0, 0, 1);
        vin_uvlo_ok = 1;
        step(1);
        chk("R1 back to idle", 1, 0, 0, 0, 1);
        step(1);
        chk("R2 restart", 2, 1, 1, 0, 1);
        step(1);
        chk("R3 to fast", 3, 2, 1, 0, 1);

        term_en = 0; pack_hot = 1; pack_cold = 1;
        step(3);
        chk("R9 temperature ignored", 3, 2, 1, 0, 0);
        bat_at_reg = 1;
        step(1);
        chk("R5 enter CV", 4, 2, 1, 0, 1);
        ichg_below_term = 1;
        step(2);
        chk("R5 no done without termination", 4, 2, 1, 0, 0);
        pack_hot = 0; pack_cold = 0; term_en = 1;
        step(1);
        chk("R5 done", 5, 0, 0, 0, 1);
        step(2);
        chk("R11 done idle", 5, 0, 0, 0, 0);

        chg_en = 0;
        step(1);
        chk("R13 disable from done", 1, 0, 0, 0, 1);
        chg_en = 1;
        step(1);
        chk("R2 cycle again", 2, 1, 1, 0, 1);
        step(1);
        chk("R3 cycle again", 3, 2, 1, 0, 1);
        step(1);
        chk("R5 cycle again CV", 4, 2, 1, 0, 1);
        step(1);
        chk("R5 cycle again done", 5, 0, 0, 0, 1);

        bat_rch_ok = 0;
        step(1);
        chk("R11 recharge restart", 2, 1, 1, 0, 1);
        bat_rch_ok = 1;
        step(1);
        chk("R11 fast", 3, 2, 1, 0, 1);
        step(2);
        chk("R11 back to done", 5, 0, 0, 0, 1);

        bat_low_ok = 0; bat_rch_ok = 0;
        step(1);
        chk("R10 probe starts", 5, 1, 0, 1, 0);
        tick = 1;
        step(4);
        chk("R10 probe running", 5, 1, 0, 1, 0);
        step(1);
        chk("R10 insertion restarts cycle", 2, 1, 1, 0, 1);
        tick = 0;

        bat_low_ok = 1; bat_rch_ok = 1;
        step(3);
        chk("R10 to done again", 5, 0, 0, 0, 1);
        bat_low_ok = 0; bat_rch_ok = 0;
        step(1);
        chk("R10 second probe", 5, 1, 0, 1, 0);
        bat_low_ok = 1; bat_rch_ok = 1;
        tick = 1;
        step(4);
        chk("R10 second probe running", 5, 1, 0, 1, 0);
        step(1);
        chk("R10 no battery stays done", 5, 0, 0, 0, 0);
        tick = 0;
        step(2);
        chk("R10 no restart", 5, 0, 0, 0, 0);

        chg_en = 0;
        step(1);
        chk("R13 to idle", 1, 0, 0, 0, 1);
        bat_low_ok = 0;
        chg_en = 1;
        step(1);
        chk("R2 precharge", 2, 1, 1, 0, 1);
        pack_cold = 1;
        step(1);
        chk("R8 suspend from precharge", 6, 0, 1, 0, 1);
        pack_cold = 0;
        step(1);
        chk("R8 resume precharge", 2, 1, 1, 0, 1);
        step(1);
        chk("R12 no pulse when steady", 2, 1, 1, 0, 0);
        pack_hot = 1;
        step(1);
        chk("R8 suspend again", 6, 0, 1, 0, 1);
        chg_en = 0;
        step(1);
        chk("R13 disable from suspend", 1, 0, 0, 0, 1);

        step(2);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule